// File: doc/BRIEF.md
# Character Display Nibble-Bus Write Controller

This block drives a character display module of the common two-line kind over a narrow four-bit bus. After reset it runs the display's power-on bring-up by itself: a long settling wait, three wake-up nibbles and one bus-width nibble, each with its own wait. It then sends five full configuration commands. Only after all of this does it offer a write port to the user.

The user side is a valid/ready port. It carries a byte and a flag that says whether the byte is a command or a character. Each accepted byte leaves on the bus as two nibbles, high nibble first. Every nibble is framed by an enable pulse, and a fixed gap follows it. The two slow commands, clear and return-home, add a longer wait after the byte. All waits are fixed cycle counts worked out from a clock-frequency parameter, so the display is never read and its busy flag is never polled.

Top module: `lcd4_ctrl`

## Requirements
- R1: `lcd_bus` bits [3:0] carry the nibble and bit 4 is the register select (0 for a command, 1 for a character). Bit 5 is the read/write line and stays 0 at all times. Bit 6 is the enable strobe.
- R2: In the cycle where the enable rises, bits [5:0] keep their previous value. The new nibble and select appear only while the enable is high. In the cycle where the enable falls, bits [5:0] are unchanged, and that falling edge is where the display takes the nibble.
- R3: A byte goes out as its high nibble, then its low nibble. After every enable fall, at least 40 µs pass before the next enable rise. Between the two nibbles of one byte the gap is at most 12 µs more than that.
- R4: After reset the enable stays low for at least 20 ms. The first four transfers are then the single nibbles 3, 3, 3, 2 with select 0. They are followed by gaps of at least 4.1 ms, 0.1 ms, 40 µs and 40 µs.
- R5: The bring-up continues with the commands 0x28, 0x08, 0x01, 0x06, 0x0C in that order, each as two nibbles with select 0.
- R6: `in_ready` is 0 from reset until the last bring-up command and its gap are complete. While `in_ready` is 1 the enable is low.
- R7: A byte is taken only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the next cycle. Asserting `in_valid` while `in_ready` is 0 produces no bus transfer.
- R8: After the command 0x01 the wait that follows the low nibble is at least 2 ms longer than the normal gap. After the command 0x02 it is at least 1.6 ms longer. The same codes sent as characters get no extra wait. The busy time of any other byte is the normal two-nibble time.
- R9: Every wait is a microsecond figure multiplied by `CLK_HZ`/1 000 000 clock cycles. `CLK_HZ` must be a whole number of MHz.
- R10: While reset is asserted, `lcd_bus` is 0 and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | User byte is present |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Byte to send |
| in_is_char | input | 1 | 1: character data, 0: command |
| lcd_bus | output | 7 | {enable, read/write, select, nibble[3:0]} |

## Verification
On every cycle, the assertions check the following:
- the data and select lines are quiet at both enable edges;
- the time from each enable fall to the next rise never drops below the nibble gap;
- the enable stays idle while ready is high;
- ready drops right after a handshake.

Only the bench scenarios can show the rest. The bench rebuilds every transferred byte from the enable falls and checks it against the bring-up order and the user bytes. It also shows that the long waits follow exactly the clear and home commands and not the same codes sent as characters, and that a valid held during bring-up or during a transfer leaves no trace on the bus.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

  // selects which extra wait follows the low nibble of a step
  typedef enum logic [2:0] {
    WS_NONE  = 3'd0,
    WS_LONG  = 3'd1,
    WS_SHORT = 3'd2,
    WS_CLEAR = 3'd3,
    WS_HOME  = 3'd4
  } wait_sel_e;

  typedef struct packed {
    logic      single;   // 1: send only the low nibble of val
    logic [7:0] val;
    wait_sel_e ws;
  } init_step_t;

  localparam int INIT_STEPS = 9;
  localparam int IDX_W      = $clog2(INIT_STEPS);

  localparam logic [7:0] CMD_CLEAR = 8'h01;
  localparam logic [7:0] CMD_HOME  = 8'h02;

  // bring-up order: wake-up nibbles, bus width nibble, configuration bytes
  function automatic init_step_t init_step(input logic [IDX_W-1:0] idx);
    init_step_t s;
    s = '{single: 1'b0, val: 8'h00, ws: WS_NONE};
    case (idx)
      4'd0: s = '{single: 1'b1, val: 8'h03, ws: WS_LONG};
      4'd1: s = '{single: 1'b1, val: 8'h03, ws: WS_SHORT};
      4'd2: s = '{single: 1'b1, val: 8'h03, ws: WS_NONE};
      4'd3: s = '{single: 1'b1, val: 8'h02, ws: WS_NONE};
      4'd4: s = '{single: 1'b0, val: 8'h28, ws: WS_NONE};
      4'd5: s = '{single: 1'b0, val: 8'h08, ws: WS_NONE};
      4'd6: s = '{single: 1'b0, val: CMD_CLEAR, ws: WS_CLEAR};
      4'd7: s = '{single: 1'b0, val: 8'h06, ws: WS_NONE};
      4'd8: s = '{single: 1'b0, val: 8'h0C, ws: WS_NONE};
      default: s = '{single: 1'b0, val: 8'h00, ws: WS_NONE};
    endcase
    return s;
  endfunction

  function automatic wait_sel_e user_wait(input logic [7:0] b, input logic is_char);
    if (!is_char && b == CMD_CLEAR) return WS_CLEAR;
    if (!is_char && b == CMD_HOME)  return WS_HOME;
    return WS_NONE;
  endfunction

endpackage

// File: rtl/lcd4_timer.sv
module lcd4_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dec_en;

  assign dec_en = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (dec_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // an expired counter stays expired until reloaded (R9)
  p_tmr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

endmodule

// File: rtl/lcd4_strobe.sv
module lcd4_strobe #(
  parameter int TW      = 8,
  parameter int STB_CYC = 1,
  parameter int GAP_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] nib,
  input  logic       rs,
  output logic       done,
  output logic       en_o,
  output logic       rs_o,
  output logic [3:0] nib_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_RISE, ST_DRIVE, ST_GAP} st_e;

  st_e          st_q, st_d;
  logic         en_q, en_d, rs_q, rs_d, prs_q, prs_d;
  logic [3:0]   nib_q, nib_d, pnib_q, pnib_d;
  logic         t_load, t_zero;
  logic [TW-1:0] t_val;

  lcd4_timer #(.W(TW), .RST_VAL(0)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  always_comb begin
    st_d   = st_q;
    en_d   = en_q;
    rs_d   = rs_q;
    nib_d  = nib_q;
    prs_d  = prs_q;
    pnib_d = pnib_q;
    t_load = 1'b0;
    t_val  = '0;
    done   = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_RISE;
        en_d   = 1'b1;          // enable first, lines untouched
        pnib_d = nib;
        prs_d  = rs;
        t_load = 1'b1;
        t_val  = TW'(STB_CYC);
      end
      ST_RISE: if (t_zero) begin
        st_d   = ST_DRIVE;
        nib_d  = pnib_q;
        rs_d   = prs_q;
        t_load = 1'b1;
        t_val  = TW'(STB_CYC);
      end
      ST_DRIVE: if (t_zero) begin
        st_d   = ST_GAP;
        en_d   = 1'b0;          // display latches here
        t_load = 1'b1;
        t_val  = TW'(GAP_CYC);
      end
      ST_GAP: if (t_zero) begin
        st_d = ST_IDLE;
        done = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      rs_q   <= 1'b0;
      nib_q  <= 4'h0;
      prs_q  <= 1'b0;
      pnib_q <= 4'h0;
    end else begin
      st_q   <= st_d;
      en_q   <= en_d;
      rs_q   <= rs_d;
      nib_q  <= nib_d;
      prs_q  <= prs_d;
      pnib_q <= pnib_d;
    end
  end

  assign en_o  = en_q;
  assign rs_o  = rs_q;
  assign nib_o = nib_q;

  // checker counter: cycles since the last enable fall, saturating
  logic [TW-1:0] since_fall_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_fall_q <= '1;
    else if (en_q)               since_fall_q <= '0;
    else if (since_fall_q != '1) since_fall_q <= since_fall_q + 1'b1;
  end

  p_rise_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $stable({rs_q, nib_q}));

  p_fall_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $stable({rs_q, nib_q}));

  p_gap_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (since_fall_q >= TW'(GAP_CYC)));

  p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == ST_IDLE));

endmodule

// File: rtl/lcd4_seq.sv
module lcd4_seq
  import lcd4_pkg::*;
#(
  parameter int TW        = 8,
  parameter int PWR_CYC   = 100,
  parameter int LONG_CYC  = 50,
  parameter int SHORT_CYC = 10,
  parameter int CLR_CYC   = 20,
  parameter int HOME_CYC  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_is_char,
  output logic       in_ready,
  output logic       stb_start,
  output logic [3:0] stb_nib,
  output logic       stb_rs,
  input  logic       stb_done
);

  typedef enum logic [2:0] {
    S_PWR, S_LOAD, S_HI, S_HI_W, S_LO, S_LO_W, S_XW, S_RDY
  } st_e;

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(INIT_STEPS - 1);

  st_e             st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]      byte_q, byte_d;
  logic            rs_q, rs_d, init_q, init_d;
  wait_sel_e       ws_q, ws_d;
  init_step_t      step;
  logic            t_load, t_zero;
  logic [TW-1:0]   t_val;

  function automatic logic [TW-1:0] ws_cycles(input wait_sel_e w);
    case (w)
      WS_LONG:  return TW'(LONG_CYC);
      WS_SHORT: return TW'(SHORT_CYC);
      WS_CLEAR: return TW'(CLR_CYC);
      WS_HOME:  return TW'(HOME_CYC);
      default:  return '0;
    endcase
  endfunction

  // the reset value is the power-on settling wait
  lcd4_timer #(.W(TW), .RST_VAL(PWR_CYC)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  assign step = init_step(idx_q);

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    byte_d    = byte_q;
    rs_d      = rs_q;
    ws_d      = ws_q;
    init_d    = init_q;
    t_load    = 1'b0;
    t_val     = '0;
    stb_start = 1'b0;
    in_ready  = 1'b0;
    case (st_q)
      S_PWR:  if (t_zero) st_d = S_LOAD;
      S_LOAD: begin
        byte_d = step.val;
        rs_d   = 1'b0;
        ws_d   = step.ws;
        st_d   = step.single ? S_LO : S_HI;
      end
      S_HI: begin
        stb_start = 1'b1;
        st_d      = S_HI_W;
      end
      S_HI_W: if (stb_done) st_d = S_LO;
      S_LO: begin
        stb_start = 1'b1;
        st_d      = S_LO_W;
      end
      S_LO_W: if (stb_done) begin
        t_load = 1'b1;
        t_val  = ws_cycles(ws_q);
        st_d   = S_XW;
      end
      S_XW: if (t_zero) begin
        if (init_q && idx_q != IDX_LAST) begin
          idx_d = idx_q + 1'b1;
          st_d  = S_LOAD;
        end else begin
          init_d = 1'b0;
          st_d   = S_RDY;
        end
      end
      S_RDY: begin
        in_ready = 1'b1;
        if (in_valid) begin
          byte_d = in_data;
          rs_d   = in_is_char;
          ws_d   = user_wait(in_data, in_is_char);
          st_d   = S_HI;
        end
      end
      default: st_d = S_PWR;
    endcase
  end

  assign stb_nib = (st_q == S_HI) ? byte_q[7:4] : byte_q[3:0];
  assign stb_rs  = rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_PWR;
      idx_q  <= '0;
      byte_q <= 8'h00;
      rs_q   <= 1'b0;
      ws_q   <= WS_NONE;
      init_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      byte_q <= byte_d;
      rs_q   <= rs_d;
      ws_q   <= ws_d;
      init_q <= init_d;
    end
  end

  p_ready_after_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !init_q);

  p_accept_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_init_no_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_start && init_q) |-> !stb_rs);

endmodule

// File: rtl/lcd4_ctrl.sv
module lcd4_ctrl #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_is_char,
  output logic [6:0] lcd_bus
);

  localparam int CPU       = CLK_HZ / 1_000_000;
  localparam int STB_CYC   = (CPU / 2 < 1) ? 1 : CPU / 2;
  localparam int GAP_CYC   = 40 * CPU;
  localparam int PWR_CYC   = 20_000 * CPU;
  localparam int LONG_CYC  = (4_100 - 40) * CPU;
  localparam int SHORT_CYC = (100 - 40) * CPU;
  localparam int CLR_CYC   = 2_000 * CPU;
  localparam int HOME_CYC  = 1_600 * CPU;
  localparam int TW        = $clog2(PWR_CYC + 1);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic       stb_start, stb_rs, stb_done;
  logic [3:0] stb_nib;
  logic       en_w, rs_w;
  logic [3:0] nib_w;

  lcd4_seq #(
    .TW(TW), .PWR_CYC(PWR_CYC), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC),
    .CLR_CYC(CLR_CYC), .HOME_CYC(HOME_CYC)
  ) seq_i (
    .clk(clk), .rst_n(rst_n_s),
    .in_valid(in_valid), .in_data(in_data), .in_is_char(in_is_char),
    .in_ready(in_ready),
    .stb_start(stb_start), .stb_nib(stb_nib), .stb_rs(stb_rs), .stb_done(stb_done)
  );

  lcd4_strobe #(.TW(TW), .STB_CYC(STB_CYC), .GAP_CYC(GAP_CYC)) stb_i (
    .clk(clk), .rst_n(rst_n_s),
    .start(stb_start), .nib(stb_nib), .rs(stb_rs), .done(stb_done),
    .en_o(en_w), .rs_o(rs_w), .nib_o(nib_w)
  );

  // bit 5 (read/write) is tied to write
  assign lcd_bus = {en_w, 1'b0, rs_w, nib_w};

  p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_ready |-> !lcd_bus[6]);

endmodule

// File: tb/lcd4_ctrl_tb.sv
`timescale 1ns/1ps
module lcd4_ctrl_tb_top;

  localparam int GAP = 40;   // CLK_HZ = 1 MHz: one cycle per microsecond (R9)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_is_char = 1'b0;
  logic       in_ready;
  logic [6:0] lcd_bus;

  always #10 clk = ~clk;

  lcd4_ctrl #(.CLK_HZ(1_000_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_is_char(in_is_char), .lcd_bus(lcd_bus)
  );

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  // ---------------- display model ----------------
  int         cyc = 0, last_fall = 0, m_cnt = 0;
  int         rw_bad = 0, rise_bad = 0, fall_bad = 0;
  logic [6:0] prev = '0;
  logic [3:0] m_nib [0:127];
  logic       m_rs  [0:127];
  int         m_gap [0:127];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      prev = '0; last_fall = cyc; m_cnt = 0;
    end else begin
      if (lcd_bus[5]) rw_bad = rw_bad + 1;
      if (lcd_bus[6] && !prev[6]) begin
        if (lcd_bus[5:0] != prev[5:0]) rise_bad = rise_bad + 1;
        if (m_cnt < 128) m_gap[m_cnt] = cyc - last_fall;
      end
      if (!lcd_bus[6] && prev[6]) begin
        if (lcd_bus[5:0] != prev[5:0]) fall_bad = fall_bad + 1;
        if (m_cnt < 128) begin
          m_nib[m_cnt] = lcd_bus[3:0];
          m_rs[m_cnt]  = lcd_bus[4];
        end
        m_cnt = m_cnt + 1;
        last_fall = cyc;
      end
      prev = lcd_bus;
    end
  end

  // ---------------- bench functions ----------------
  function automatic int exp_extra(input logic [7:0] b, input logic c);
    if (!c && b == 8'h01) return 2000;
    if (!c && b == 8'h02) return 1600;
    return 0;
  endfunction

  function automatic logic [3:0] init_nib(input int i);
    logic [3:0] t [0:13];
    t = '{4'h3, 4'h3, 4'h3, 4'h2, 4'h2, 4'h8, 4'h0, 4'h8,
          4'h0, 4'h1, 4'h0, 4'h6, 4'h0, 4'hC};
    return t[i];
  endfunction

  function automatic int init_gap_min(input int i);
    case (i)
      0:  return 20000;
      1:  return 4100;
      2:  return 100;
      10: return 2000 + GAP;
      default: return GAP;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // ---------------- user-side stimulus ----------------
  logic [7:0] exp_b [0:63];
  logic       exp_c [0:63];
  int         nexp = 0;

  task automatic send(input logic [7:0] b, input logic c, input bit hold);
    int n;
    while (!in_ready) @(negedge clk);
    in_data = b; in_is_char = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_b[nexp] = b; exp_c[nexp] = c; nexp = nexp + 1;
    chk(!in_ready, "R7 ready after accept", int'(in_ready), 0);
    n = 0;
    while (!in_ready) begin
      if (hold && n < 30) begin in_valid = 1'b1; in_data = 8'hAA; end
      else in_valid = 1'b0;
      @(negedge clk);
      n = n + 1;
    end
    in_valid = 1'b0;
    chk(n >= 2*GAP + exp_extra(b, c) && n <= 2*GAP + exp_extra(b, c) + 24,
        "R8 busy time", n, 2*GAP + exp_extra(b, c));
  endtask

  initial begin
    int t_ready;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(lcd_bus == 7'h00, "R10 bus in reset", int'(lcd_bus), 0);
    chk(!in_ready, "R10 ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;

    // valid during bring-up must be ignored (R7)
    repeat (100) @(negedge clk);
    chk(!in_ready, "R6 ready low in bring-up", int'(in_ready), 0);
    in_valid = 1'b1; in_data = 8'h55; in_is_char = 1'b1;
    repeat (50) @(negedge clk);
    in_valid = 1'b0;

    while (!in_ready) @(negedge clk);
    t_ready = cyc;
    chk(t_ready >= 26680, "R6 ready time", t_ready, 26680);
    chk(t_ready - last_fall >= GAP, "R6 final gap", t_ready - last_fall, GAP);
    chk(m_cnt == 14, "R7 no bring-up insertion", m_cnt, 14);
    for (int i = 0; i < 14; i++) begin
      chk(m_nib[i] == init_nib(i), (i < 4) ? "R4 nibble" : "R5 nibble",
          int'(m_nib[i]), int'(init_nib(i)));
      chk(m_rs[i] == 1'b0, "R1 bring-up select", int'(m_rs[i]), 0);
      chk(m_gap[i] >= init_gap_min(i), (i == 10) ? "R8 clear wait" : "R4 gap",
          m_gap[i], init_gap_min(i));
    end

    // directed corners
    send(8'h01, 1'b0, 1'b0);   // clear
    send(8'h02, 1'b0, 1'b0);   // home
    send(8'h01, 1'b1, 1'b0);   // character 0x01: no extra wait
    send(8'h02, 1'b1, 1'b0);
    send(8'h41, 1'b1, 1'b1);   // valid held while busy (R7)
    send(8'h00, 1'b0, 1'b0);
    send(8'hFF, 1'b1, 1'b0);
    send(8'h80, 1'b0, 1'b0);
    // constrained random
    for (int k = 0; k < 20; k++) begin
      logic [7:0] b;
      logic       c;
      b = 8'($urandom);
      c = 1'($urandom);
      if (($urandom % 8) == 0) b = 8'(1 + ($urandom % 2));
      send(b, c, ($urandom % 4) == 0);
    end
    repeat (100) @(negedge clk);

    chk(m_cnt == 14 + 2*nexp, "R7 transfer count", m_cnt, 14 + 2*nexp);
    for (int k = 0; k < nexp; k++) begin
      int h;
      h = 14 + 2*k;
      chk({m_nib[h], m_nib[h+1]} == exp_b[k], "R3 byte order",
          int'({m_nib[h], m_nib[h+1]}), int'(exp_b[k]));
      chk(m_rs[h] == exp_c[k] && m_rs[h+1] == exp_c[k], "R1 select",
          int'(m_rs[h]), int'(exp_c[k]));
      chk(m_gap[h+1] >= GAP && m_gap[h+1] <= GAP + 12, "R3 nibble gap",
          m_gap[h+1], GAP);
      if (k + 1 < nexp)
        chk(m_gap[h+2] >= GAP + exp_extra(exp_b[k], exp_c[k]), "R8 wait after byte",
            m_gap[h+2], GAP + exp_extra(exp_b[k], exp_c[k]));
    end
    chk(rw_bad == 0, "R1 read/write low", rw_bad, 0);
    chk(rise_bad == 0, "R2 quiet at rise", rise_bad, 0);
    chk(fall_bad == 0, "R2 stable at fall", fall_bad, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
      $finish;
    end
  end

endmodule